// File: doc/BRIEF.md
# Predicated Pairwise Vector Adder

This block adds neighbouring element pairs of two vector operands and interleaves the sums into a single result vector. Each even-numbered result lane takes the sum of one pair of elements from the first operand. Each odd-numbered result lane takes the sum of the matching pair of elements from the second operand. A per-byte predicate decides which lanes are written. A lane whose predicate is clear returns the first operand's element at that index unchanged, because the first operand is treated as the destination that the result overwrites.

The element size is chosen per operation from four widths: 8, 16, 32 and 64 bits. All sums are unsigned and wrap at the element width. The datapath is combinational. One register stage captures the result when an input strobe is high, and a valid flag follows one cycle later. The vector width is a parameter and must be a multiple of 128 bits.

Top module: `pred_pair_add`

## Requirements
- R1: The element width is 8 << size_i, giving 8, 16, 32 or 64 bits for size_i = 0, 1, 2 or 3. The vector holds VEC_W / width elements, and element e occupies bits [e*width +: width].
- R2: When the predicate bit of element e is 0, result element e equals op_a_i element e.
- R3: When element e is active and e is even, result element e equals op_a_i element e plus op_a_i element e+1.
- R4: When element e is active and e is odd, result element e equals op_b_i element e-1 plus op_b_i element e.
- R5: Sums are unsigned and truncated to the element width, so they wrap modulo 2^width. No carry appears in any neighbouring element.
- R6: The predicate has one bit per byte. Bit pred_i[e*width/8] alone decides whether element e is active; the other predicate bits inside that element have no effect.
- R7: When valid_i is high at a rising edge of clk_i, res_o shows the result for those inputs after that edge, and valid_o is high for exactly the cycle after each cycle in which valid_i was high.
- R8: When valid_i is low at a rising edge, res_o keeps its previous value.
- R9: While rst_ni is low, valid_o and res_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe; captures a result |
| size_i | input | 2 | Element size selector (8 << size_i bits) |
| op_a_i | input | VEC_W | First operand, also the destination |
| op_b_i | input | VEC_W | Second operand |
| pred_i | input | VEC_W/8 | Predicate, one bit per byte |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| res_o | output | VEC_W | Registered result vector |

## Verification
The bench uses all-ones operands at every element size so that each pair sum overflows. A design that let the carry propagate would corrupt the neighbouring element, and a design that saturated would return all ones instead of the wrapped value. It also sets only the upper predicate bits of each element, leaving the lowest bit clear. A design that ORed the predicate bits across the element, or read the wrong bit, would then write sums where the lanes should hold the operand. Random predicates that mix active and inactive lanes catch two further faults: using the wrong operand for even or odd lanes, and pairing the wrong neighbours. A further check changes the inputs while valid_i is low and expects res_o to hold, which catches a register that loads without the strobe.

// File: rtl/pred_pair_add_pkg.sv
package pred_pair_add_pkg;
  localparam int unsigned NUM_SIZES = 4;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } elem_size_e;

  function automatic int unsigned elem_bits(input int unsigned sel);
    return 8 << sel;
  endfunction
endpackage

// File: rtl/pred_pair_add_act.sv
// Picks the governing predicate bit of each element.
module pred_pair_add_act #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned ESZ   = 8,
  localparam int unsigned N_EL = VEC_W / ESZ,
  localparam int unsigned N_PB = VEC_W / 8
) (
  input  logic [N_PB-1:0] pred_i,
  output logic [N_EL-1:0] act_o
);
  localparam int unsigned BPE = ESZ / 8;

  for (genvar e = 0; e < N_EL; e++) begin : g_el
    assign act_o[e] = pred_i[e*BPE];
  end
endmodule

// File: rtl/pred_pair_add_lanes.sv
// Pairwise sums for one element size, interleaved and predicated.
module pred_pair_add_lanes #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned ESZ   = 8,
  localparam int unsigned N_EL = VEC_W / ESZ,
  localparam int unsigned N_PB = VEC_W / 8
) (
  input  logic [VEC_W-1:0] op_a_i,
  input  logic [VEC_W-1:0] op_b_i,
  input  logic [N_PB-1:0]  pred_i,
  output logic [VEC_W-1:0] res_o
);
  logic [N_EL-1:0] act;

  pred_pair_add_act #(.VEC_W(VEC_W), .ESZ(ESZ)) u_act (
    .pred_i (pred_i),
    .act_o  (act)
  );

  for (genvar e = 0; e < N_EL; e++) begin : g_lane
    logic [ESZ-1:0] sum;
    if ((e % 2) == 0) begin : g_even
      assign sum = op_a_i[e*ESZ +: ESZ] + op_a_i[(e+1)*ESZ +: ESZ];
    end else begin : g_odd
      assign sum = op_b_i[(e-1)*ESZ +: ESZ] + op_b_i[e*ESZ +: ESZ];
    end
    assign res_o[e*ESZ +: ESZ] = act[e] ? sum : op_a_i[e*ESZ +: ESZ];
  end
endmodule

// File: rtl/pred_pair_add.sv
module pred_pair_add
  import pred_pair_add_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned N_PB = VEC_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       size_i,
  input  logic [VEC_W-1:0] op_a_i,
  input  logic [VEC_W-1:0] op_b_i,
  input  logic [N_PB-1:0]  pred_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o
);
  logic [VEC_W-1:0] cand [NUM_SIZES];
  logic [VEC_W-1:0] res_sel;
  logic [VEC_W-1:0] res_q;
  logic             valid_q;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    pred_pair_add_lanes #(.VEC_W(VEC_W), .ESZ(elem_bits(s))) u_lanes (
      .op_a_i (op_a_i),
      .op_b_i (op_b_i),
      .pred_i (pred_i),
      .res_o  (cand[s])
    );
  end

  assign res_sel = cand[size_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_sel;
    end
  end

  assign valid_o = valid_q;
  assign res_o   = res_q;

  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  p_inactive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pred_i[0]) |=> res_o[7:0] == $past(op_a_i[7:0]));
  p_even_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i[0] && size_i == SZ_8) |=>
      res_o[7:0] == 8'($past(op_a_i[7:0]) + $past(op_a_i[15:8])));
  p_odd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pred_i[1] && size_i == SZ_8) |=>
      res_o[15:8] == 8'($past(op_b_i[7:0]) + $past(op_b_i[15:8])));
  p_upper_pred_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pred_i[0] && size_i == SZ_64) |=>
      res_o[63:0] == $past(op_a_i[63:0]));
endmodule

// File: tb/pred_pair_add_bench.sv
module pred_pair_add_bench;
  localparam int unsigned VEC_W = 128;
  localparam int unsigned N_PB  = VEC_W / 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [1:0]       size_i = '0;
  logic [VEC_W-1:0] op_a_i = '0;
  logic [VEC_W-1:0] op_b_i = '0;
  logic [N_PB-1:0]  pred_i = '0;
  logic             valid_o;
  logic [VEC_W-1:0] res_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pred_pair_add #(.VEC_W(VEC_W)) u_pred_pair_add (
    .clk_i, .rst_ni, .valid_i, .size_i, .op_a_i, .op_b_i, .pred_i,
    .valid_o, .res_o
  );

  function automatic logic [VEC_W-1:0] ref_model(
      input logic [1:0] sz, input logic [VEC_W-1:0] a,
      input logic [VEC_W-1:0] b, input logic [N_PB-1:0] p);
    int unsigned esz = 8 << sz;
    int unsigned n = VEC_W / esz;
    logic [63:0] m = (esz == 64) ? '1 : ((64'd1 << esz) - 64'd1);
    logic [VEC_W-1:0] r = '0;
    for (int e = 0; e < n; e++) begin
      logic [63:0] x, y, v;
      if (!p[e*esz/8]) v = 64'(a >> (e*esz)) & m;
      else if (e % 2 == 0) begin
        x = 64'(a >> (e*esz)) & m;
        y = 64'(a >> ((e+1)*esz)) & m;
        v = (x + y) & m;
      end else begin
        x = 64'(b >> ((e-1)*esz)) & m;
        y = 64'(b >> (e*esz)) & m;
        v = (x + y) & m;
      end
      r = r | (VEC_W'(v) << (e*esz));
    end
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v = '0;
    for (int i = 0; i < VEC_W/32; i++) v = (v << 32) | VEC_W'($urandom);
    return v;
  endfunction

  task automatic check(input string req, input logic [VEC_W-1:0] act,
                       input logic [VEC_W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [1:0] sz,
                       input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                       input logic [N_PB-1:0] p);
    @(negedge clk_i);
    valid_i = 1'b1; size_i = sz; op_a_i = a; op_b_i = b; pred_i = p;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " result"}, res_o, ref_model(sz, a, b, p));
    check("R7 valid_o", VEC_W'(valid_o), VEC_W'(1));
  endtask

  initial begin
    logic [VEC_W-1:0] held;
    void'($urandom(32'd1234));
    #1;
    check("R9 reset res_o", res_o, '0);
    check("R9 reset valid_o", VEC_W'(valid_o), '0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int s = 0; s < 4; s++) begin
      apply("R1 R3 R4 all active", 2'(s), rnd_vec(), rnd_vec(), '1);
      apply("R2 all inactive", 2'(s), rnd_vec(), rnd_vec(), '0);
      apply("R5 wrap", 2'(s), '1, '1, '1);
    end
    // R6: only the non-governing predicate bits set
    apply("R6 upper bits 16b", 2'd1, rnd_vec(), rnd_vec(), {8{2'b10}});
    apply("R6 upper bits 32b", 2'd2, rnd_vec(), rnd_vec(), {4{4'b1110}});
    apply("R6 upper bits 64b", 2'd3, rnd_vec(), rnd_vec(), {2{8'hFE}});
    apply("R5 wrap 8b", 2'd0, {16{8'h80}}, {16{8'hC1}}, '1);

    // R8: inputs change with valid_i low, result must hold
    held = res_o;
    @(negedge clk_i);
    op_a_i = rnd_vec(); op_b_i = rnd_vec(); pred_i = '1; size_i = 2'd2;
    repeat (2) @(negedge clk_i);
    check("R8 hold", res_o, held);
    check("R7 valid low", VEC_W'(valid_o), '0);

    for (int i = 0; i < 200; i++)
      apply("R2 R3 R4 random", 2'($urandom_range(0, 3)), rnd_vec(), rnd_vec(),
            N_PB'($urandom));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule